// File: doc/BRIEF.md
# Radix page table walker

This block turns an effective address into a real address by walking a multi-level radix page table in memory. A root-lookup stage supplies the byte address of the root directory and the index width of the root level. The walker then fetches one 8-byte directory entry per level. At each level it takes the next group of high-order effective-address bits as the index. The width of that group is the size exponent of the current level. Each non-leaf entry carries the base and size exponent of the level below it, so the index width can differ from level to level. The walk ends when an entry has its leaf bit set, not after a fixed number of levels.

A leaf yields the real address together with the reference, change, storage-attribute and access-authority fields. An invalid entry, a size exponent below the minimum, an index that runs past the translated range, or a walk that is too deep ends the walk with a fault code. The client starts a translation with a one-cycle strobe while the walker is idle. It sees the outcome as a one-cycle done strobe, with the fault code and the result fields valid in that cycle.

Top module: `ptw_walker`

## Requirements
- R1: A start strobe is accepted only while busy is 0. A start while busy is 1 is ignored, and the walk in progress completes with its own result.
- R2: The root request address is root base + 8 * index. For a later level it is (entry base) + 8 * index. The index is the next `size` bits of effective address, taken downward from bit 51 of the 52 translated bits.
- R3: A directory entry is decoded with bit numbering from the most significant end (entry bit k is data bit 63-k). Bit 0 is valid and bit 1 is leaf. In a non-leaf entry, bits 4..55 hold the next base shifted right by 8, and bits 59..63 hold the next size exponent.
- R4: On a leaf, the real address is (page number in bits 7..51) << 12, OR'd with the effective-address bits that no index consumed.
- R5: On a leaf, the outputs carry the reference bit (entry bit 55), the change bit (entry bit 56) and the authority code (bits 60..63). They also carry the attribute (bits 58..59), where 00 is normal memory, 01 is strongly ordered, 10 is non-idempotent and 11 is tolerant I/O.
- R6: A fetched entry with valid = 0 ends the walk with fault code 1.
- R7: A level size exponent below 5, at the root or in an entry, ends the walk with fault code 2, and no request is made for that level.
- R8: If the indices consumed would exceed 52 bits, or any effective-address bit from 52 upward is set, the walk ends with fault code 3 and no request is made for that level. The size check of R7 takes priority.
- R9: If the fourth fetched entry is still a non-leaf, the walk ends with fault code 4 after exactly 4 requests.
- R10: done is a one-cycle strobe. fault is 0 on success, and the result fields are 0 on a fault. busy is 0 again in the cycle after done.
- R11: The memory request is a one-cycle pulse. At most one request is outstanding, and a new one follows only after a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a translation (one cycle) |
| ea_i | input | 64 | Effective address to translate |
| root_base_i | input | 64 | Byte address of the root directory |
| root_bits_i | input | 5 | Index width of the root level |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Entry read request pulse |
| mem_addr_o | output | 64 | Byte address of the entry to read |
| mem_rsp_i | input | 1 | Entry read response valid |
| mem_data_i | input | 64 | Entry read data |
| done_o | output | 1 | Walk finished strobe |
| fault_o | output | 3 | 0 ok, 1 invalid, 2 size, 3 range, 4 depth |
| real_addr_o | output | 64 | Translated real address |
| ref_o | output | 1 | Leaf reference bit |
| chg_o | output | 1 | Leaf change bit |
| attr_o | output | 2 | Leaf storage attribute |
| auth_o | output | 4 | Leaf access-authority code |

## Verification
The bench builds the walker with its default parameters: 52 translated bits, a minimum size exponent of 5 and a depth limit of 4. It runs against a response model with a two-cycle latency. With those values a four-level walk with 13/9/9/9-bit indices and a 12-bit page offset can be run, as can a two-level walk with a large 30-bit page offset. A chain of four 5-bit directories reaches the depth fault. Root widths of 31 and 4 reach the range and size faults at different levels.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ADDR_W = 64;
    localparam int ENT_W  = 64;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_INVALID = 3'd1,
        FLT_SIZE    = 3'd2,
        FLT_RANGE   = 3'd3,
        FLT_DEPTH   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ATTR_NORMAL   = 2'b00,
        ATTR_ORDERED  = 2'b01,
        ATTR_NONIDEM  = 2'b10,
        ATTR_TOLERANT = 2'b11
    } attr_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } state_e;

    typedef struct packed {
        logic              valid;
        logic              leaf;
        logic [ADDR_W-1:0] next_base;
        logic [4:0]        next_size;
        logic [ADDR_W-1:0] page_addr;
        logic              ref_bit;
        logic              chg_bit;
        attr_e             attr;
        logic [3:0]        auth;
    } entry_t;

    // Entry bits are numbered from the most significant end.
    function automatic int lsb_pos(input int msb0_pos);
        return ENT_W - 1 - msb0_pos;
    endfunction

    function automatic logic [ADDR_W-1:0] low_mask(input logic [6:0] nbits);
        return (64'd1 << nbits) - 64'd1;
    endfunction

endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
(
    input  logic [ENT_W-1:0] raw_i,
    output entry_t           ent_o
);
    localparam int V_POS   = lsb_pos(0);
    localparam int L_POS   = lsb_pos(1);
    localparam int NB_HI   = lsb_pos(4);
    localparam int NB_LO   = lsb_pos(55);
    localparam int NS_HI   = lsb_pos(59);
    localparam int NS_LO   = lsb_pos(63);
    localparam int PN_HI   = lsb_pos(7);
    localparam int PN_LO   = lsb_pos(51);
    localparam int R_POS   = lsb_pos(55);
    localparam int C_POS   = lsb_pos(56);
    localparam int AT_HI   = lsb_pos(58);
    localparam int AT_LO   = lsb_pos(59);
    localparam int AU_HI   = lsb_pos(60);
    localparam int AU_LO   = lsb_pos(63);
    localparam int NB_W    = NB_HI - NB_LO + 1;
    localparam int PN_W    = PN_HI - PN_LO + 1;

    always_comb begin
        ent_o.valid     = raw_i[V_POS];
        ent_o.leaf      = raw_i[L_POS];
        ent_o.next_base = ADDR_W'({raw_i[NB_HI:NB_LO], 8'd0});
        ent_o.next_size = raw_i[NS_HI:NS_LO];
        ent_o.page_addr = ADDR_W'({raw_i[PN_HI:PN_LO], 12'd0});
        ent_o.ref_bit   = raw_i[R_POS];
        ent_o.chg_bit   = raw_i[C_POS];
        ent_o.attr      = attr_e'(raw_i[AT_HI:AT_LO]);
        ent_o.auth      = raw_i[AU_HI:AU_LO];
    end

    initial begin
        assert (NB_W == 52 && PN_W == 45)
            else $error("entry field widths mismatch");
    end
endmodule

// File: rtl/ptw_index_gen.sv
module ptw_index_gen
    import ptw_pkg::*;
#(
    parameter int XLAT_BITS = 52,
    parameter int MIN_SIZE  = 5,
    parameter int REM_W     = 7
) (
    input  logic [ADDR_W-1:0] ea_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [4:0]        size_i,
    input  logic [REM_W-1:0]  rem_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [REM_W-1:0]  rem_next_o,
    output fault_e            fault_o
);
    localparam logic [ADDR_W-1:0] HI_MASK = ~((64'd1 << XLAT_BITS) - 64'd1);

    logic              high_bad;
    logic              too_small;
    logic              too_wide;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        high_bad   = |(ea_i & HI_MASK);
        too_small  = int'(size_i) < MIN_SIZE;
        too_wide   = int'(size_i) > int'(rem_i);
        rem_next_o = rem_i - REM_W'(size_i);
        idx        = (ea_i >> rem_next_o) & ((64'd1 << size_i) - 64'd1);
        addr_o     = base_i + (idx << 3);
        if (too_small)
            fault_o = FLT_SIZE;
        else if (high_bad || too_wide)
            fault_o = FLT_RANGE;
        else
            fault_o = FLT_NONE;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int XLAT_BITS  = 52,
    parameter int MIN_SIZE   = 5,
    parameter int MAX_LEVELS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [63:0] ea_i,
    input  logic [63:0] root_base_i,
    input  logic [4:0]  root_bits_i,
    output logic        busy_o,
    output logic        mem_req_o,
    output logic [63:0] mem_addr_o,
    input  logic        mem_rsp_i,
    input  logic [63:0] mem_data_i,
    output logic        done_o,
    output logic [2:0]  fault_o,
    output logic [63:0] real_addr_o,
    output logic        ref_o,
    output logic        chg_o,
    output logic [1:0]  attr_o,
    output logic [3:0]  auth_o
);
    localparam int REM_W = 7;
    localparam int LVL_W = $clog2(MAX_LEVELS + 1);

    state_e             state_q;
    logic [ADDR_W-1:0]  ea_q;
    logic [ADDR_W-1:0]  base_q;
    logic [4:0]         size_q;
    logic [REM_W-1:0]   rem_q;
    logic [LVL_W-1:0]   lvl_q;
    logic               req_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               done_q;
    fault_e             fault_q;
    logic [ADDR_W-1:0]  real_q;
    logic               ref_q;
    logic               chg_q;
    attr_e              attr_q;
    logic [3:0]         auth_q;

    logic [ADDR_W-1:0]  lvl_addr;
    logic [REM_W-1:0]   rem_next;
    fault_e             lvl_fault;
    entry_t             ent;

    ptw_index_gen #(
        .XLAT_BITS (XLAT_BITS),
        .MIN_SIZE  (MIN_SIZE),
        .REM_W     (REM_W)
    ) u_index (
        .ea_i       (ea_q),
        .base_i     (base_q),
        .size_i     (size_q),
        .rem_i      (rem_q),
        .addr_o     (lvl_addr),
        .rem_next_o (rem_next),
        .fault_o    (lvl_fault)
    );

    ptw_entry_decode u_decode (
        .raw_i (mem_data_i),
        .ent_o (ent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ea_q    <= '0;
            base_q  <= '0;
            size_q  <= '0;
            rem_q   <= '0;
            lvl_q   <= '0;
            req_q   <= 1'b0;
            addr_q  <= '0;
            done_q  <= 1'b0;
            fault_q <= FLT_NONE;
            real_q  <= '0;
            ref_q   <= 1'b0;
            chg_q   <= 1'b0;
            attr_q  <= ATTR_NORMAL;
            auth_q  <= '0;
        end else begin
            done_q <= 1'b0;
            req_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ea_q    <= ea_i;
                        base_q  <= root_base_i;
                        size_q  <= root_bits_i;
                        rem_q   <= REM_W'(XLAT_BITS);
                        lvl_q   <= '0;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (lvl_fault != FLT_NONE) begin
                        done_q  <= 1'b1;
                        fault_q <= lvl_fault;
                        real_q  <= '0;
                        ref_q   <= 1'b0;
                        chg_q   <= 1'b0;
                        attr_q  <= ATTR_NORMAL;
                        auth_q  <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        req_q   <= 1'b1;
                        addr_q  <= lvl_addr;
                        rem_q   <= rem_next;
                        lvl_q   <= lvl_q + 1'b1;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_i) begin
                        if (ent.valid && ent.leaf) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_NONE;
                            real_q  <= ent.page_addr | (ea_q & low_mask(rem_q));
                            ref_q   <= ent.ref_bit;
                            chg_q   <= ent.chg_bit;
                            attr_q  <= ent.attr;
                            auth_q  <= ent.auth;
                            state_q <= ST_IDLE;
                        end else if (!ent.valid || lvl_q == LVL_W'(MAX_LEVELS)) begin
                            done_q  <= 1'b1;
                            fault_q <= ent.valid ? FLT_DEPTH : FLT_INVALID;
                            real_q  <= '0;
                            ref_q   <= 1'b0;
                            chg_q   <= 1'b0;
                            attr_q  <= ATTR_NORMAL;
                            auth_q  <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            base_q  <= ent.next_base;
                            size_q  <= ent.next_size;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = state_q != ST_IDLE;
    assign mem_req_o   = req_q;
    assign mem_addr_o  = addr_q;
    assign done_o      = done_q;
    assign fault_o     = fault_q;
    assign real_addr_o = real_q;
    assign ref_o       = ref_q;
    assign chg_o       = chg_q;
    assign attr_o      = attr_q;
    assign auth_o      = auth_q;

    // R10: completion is a single-cycle strobe
    assert_done_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R11: request pulses never run back to back
    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o);

    // R11: a request is only visible while awaiting its response
    assert_req_waits_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> state_q == ST_WAIT);

    // R7: no request is issued for an undersized level
    assert_req_size_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_o) |-> int'($past(size_q)) >= MIN_SIZE);

    // R9: the level counter never passes the depth limit
    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (rst)
        int'(lvl_q) <= MAX_LEVELS);

    // R1: a new walk starts only from idle
    assert_start_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(ea_q));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] ea = '0;
    logic [63:0] root_base = '0;
    logic [4:0]  root_bits = '0;
    logic        busy, mem_req, mem_rsp, done, ref_b, chg_b;
    logic [63:0] mem_addr, mem_data, real_addr;
    logic [2:0]  fault;
    logic [1:0]  attr;
    logic [3:0]  auth;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ptw_walker dut (
        .clk (clk), .rst (rst), .start_i (start), .ea_i (ea),
        .root_base_i (root_base), .root_bits_i (root_bits),
        .busy_o (busy), .mem_req_o (mem_req), .mem_addr_o (mem_addr),
        .mem_rsp_i (mem_rsp), .mem_data_i (mem_data), .done_o (done),
        .fault_o (fault), .real_addr_o (real_addr), .ref_o (ref_b),
        .chg_o (chg_b), .attr_o (attr), .auth_o (auth)
    );

    // memory model with a two-cycle response latency
    logic [63:0] mem [logic [63:0]];
    logic        pend = 1'b0;
    logic [63:0] pend_addr = '0;
    int          dly = 0;
    int          nreq = 0;
    int          b2b = 0;
    logic        prev_req = 1'b0;
    logic [63:0] req_log [64];

    initial begin
        mem_rsp  = 1'b0;
        mem_data = '0;
    end

    always @(posedge clk) begin
        mem_rsp <= 1'b0;
        prev_req <= mem_req;
        if (mem_req) begin
            pend      <= 1'b1;
            pend_addr <= mem_addr;
            dly       <= 2;
            req_log[nreq % 64] <= mem_addr;
            nreq      <= nreq + 1;
            if (prev_req) b2b <= b2b + 1;
        end else if (pend) begin
            if (dly == 0) begin
                mem_rsp  <= 1'b1;
                mem_data <= mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
                pend     <= 1'b0;
            end else begin
                dly <= dly - 1;
            end
        end
    end

    function automatic logic [63:0] dir_ent(input logic [63:0] base, input logic [4:0] sz);
        logic [63:0] e = '0;
        e[63]   = 1'b1;
        e[59:8] = base[59:8];
        e[4:0]  = sz;
        return e;
    endfunction

    function automatic logic [63:0] leaf_ent(input logic [44:0] rpn, input logic r,
                                             input logic c, input logic [1:0] at,
                                             input logic [3:0] au);
        logic [63:0] e = '0;
        e[63]    = 1'b1;
        e[62]    = 1'b1;
        e[56:12] = rpn;
        e[8]     = r;
        e[7]     = c;
        e[5:4]   = at;
        e[3:0]   = au;
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // captured outcome of the last walk
    logic [2:0]  r_fault;
    logic [63:0] r_real;
    logic        r_ref, r_chg;
    logic [1:0]  r_attr;
    logic [3:0]  r_auth;
    int          r_nreq;
    int          r_first;

    task automatic run_walk(input logic [63:0] a, input logic [63:0] rb,
                            input logic [4:0] rbits, input bit poke_busy);
        int t = 0;
        @(negedge clk);
        r_first   = nreq;
        ea        = a;
        root_base = rb;
        root_bits = rbits;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && t < 300) begin
            if (poke_busy && t == 3) begin
                chk(busy == 1'b1, "R1 busy during walk", 64'(busy), 64'd1);
                ea        = 64'h0000_0080_4123_4567;
                root_base = 64'h50000;
                start     = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R10 walk completes", 64'(done), 64'd1);
        r_fault = fault;
        r_real  = real_addr;
        r_ref   = ref_b;
        r_chg   = chg_b;
        r_attr  = attr;
        r_auth  = auth;
        r_nreq  = nreq - r_first;
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", 64'(done), 64'd0);
        chk(busy == 1'b0, "R10 idle after done", 64'(busy), 64'd0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0 && fault == 3'd0,
            "R10 reset state", {busy, done, mem_req, fault}, 64'd0);
    endtask

    task automatic t_four_level();
        logic [63:0] a = (64'd5 << 39) | (64'd3 << 30) | (64'd7 << 21) | (64'd2 << 12) | 64'hABC;
        run_walk(a, 64'h10000, 5'd13, 1'b0);
        chk(r_fault == 3'd0, "R4 four-level no fault", 64'(r_fault), 64'd0);
        chk(r_nreq == 4, "R2 four requests", 64'(r_nreq), 64'd4);
        chk(req_log[r_first % 64] == 64'h10028, "R2 root addr", req_log[r_first % 64], 64'h10028);
        chk(req_log[(r_first + 1) % 64] == 64'h20018, "R3 level-2 addr", req_log[(r_first + 1) % 64], 64'h20018);
        chk(req_log[(r_first + 2) % 64] == 64'h30038, "R2 level-3 addr", req_log[(r_first + 2) % 64], 64'h30038);
        chk(req_log[(r_first + 3) % 64] == 64'h40010, "R2 level-4 addr", req_log[(r_first + 3) % 64], 64'h40010);
        chk(r_real == 64'h1234_5ABC, "R4 real addr", r_real, 64'h1234_5ABC);
        chk({r_ref, r_chg, r_attr, r_auth} == {1'b1, 1'b0, 2'b10, 4'hA},
            "R5 leaf fields", 64'({r_ref, r_chg, r_attr, r_auth}), 64'({1'b1, 1'b0, 2'b10, 4'hA}));
    endtask

    task automatic t_big_page();
        run_walk(64'h0000_0081_0123_4567, 64'h50000, 5'd13, 1'b0);
        chk(r_fault == 3'd0, "R4 big page no fault", 64'(r_fault), 64'd0);
        chk(r_nreq == 2, "R2 two requests", 64'(r_nreq), 64'd2);
        chk(r_real == 64'h4123_4567, "R4 30-bit offset", r_real, 64'h4123_4567);
        chk({r_ref, r_chg, r_attr, r_auth} == {1'b0, 1'b1, 2'b01, 4'h5},
            "R5 ordered attr", 64'({r_ref, r_chg, r_attr, r_auth}), 64'({1'b0, 1'b1, 2'b01, 4'h5}));
    endtask

    task automatic t_invalid();
        run_walk(64'd2 << 39, 64'h80000, 5'd13, 1'b0);
        chk(r_fault == 3'd1, "R6 invalid fault", 64'(r_fault), 64'd1);
        chk(r_nreq == 1 && r_real == 64'd0, "R6 one request, zero result", r_real, 64'd0);
    endtask

    task automatic t_small_size();
        run_walk(64'd0, 64'h90000, 5'd13, 1'b0);
        chk(r_fault == 3'd2, "R7 entry size 4", 64'(r_fault), 64'd2);
        chk(r_nreq == 1, "R7 no request after small size", 64'(r_nreq), 64'd1);
        run_walk(64'd0, 64'h90000, 5'd4, 1'b0);
        chk(r_fault == 3'd2, "R7 root size 4", 64'(r_fault), 64'd2);
        chk(r_nreq == 0, "R7 no root request", 64'(r_nreq), 64'd0);
    endtask

    task automatic t_range();
        run_walk(64'd0, 64'hC0000, 5'd31, 1'b0);
        chk(r_fault == 3'd3, "R8 index past 52 bits", 64'(r_fault), 64'd3);
        chk(r_nreq == 1, "R8 one request", 64'(r_nreq), 64'd1);
        run_walk(64'h1000_0000_0000_0000, 64'h10000, 5'd13, 1'b0);
        chk(r_fault == 3'd3, "R8 high EA bit", 64'(r_fault), 64'd3);
        chk(r_nreq == 0, "R8 no request", 64'(r_nreq), 64'd0);
    endtask

    task automatic t_depth();
        run_walk(64'd0, 64'hD0000, 5'd5, 1'b0);
        chk(r_fault == 3'd4, "R9 depth fault", 64'(r_fault), 64'd4);
        chk(r_nreq == 4, "R9 four requests", 64'(r_nreq), 64'd4);
    endtask

    task automatic t_busy_ignore();
        logic [63:0] a = (64'd5 << 39) | (64'd3 << 30) | (64'd7 << 21) | (64'd2 << 12) | 64'hABC;
        run_walk(a, 64'h10000, 5'd13, 1'b1);
        chk(r_real == 64'h1234_5ABC, "R1 start while busy ignored", r_real, 64'h1234_5ABC);
        chk(r_nreq == 4, "R1 request count unchanged", 64'(r_nreq), 64'd4);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // four-level table
        mem[64'h10028] = dir_ent(64'h20000, 5'd9);
        mem[64'h20018] = dir_ent(64'h30000, 5'd9);
        mem[64'h30038] = dir_ent(64'h40000, 5'd9);
        mem[64'h40010] = leaf_ent(45'h12345, 1'b1, 1'b0, 2'b10, 4'hA);
        // two-level table, large page
        mem[64'h50008] = dir_ent(64'h60000, 5'd9);
        mem[64'h60020] = leaf_ent(45'h40000, 1'b0, 1'b1, 2'b01, 4'h5);
        // small next size
        mem[64'h90000] = dir_ent(64'hA0000, 5'd4);
        // wide next size
        mem[64'hC0000] = dir_ent(64'hB0000, 5'd31);
        // endless chain
        mem[64'hD0000] = dir_ent(64'hD1000, 5'd5);
        mem[64'hD1000] = dir_ent(64'hD2000, 5'd5);
        mem[64'hD2000] = dir_ent(64'hD3000, 5'd5);
        mem[64'hD3000] = dir_ent(64'hD4000, 5'd5);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_four_level();
        t_big_page();
        t_invalid();
        t_small_size();
        t_range();
        t_depth();
        t_busy_ignore();
        chk(b2b == 0, "R11 no back-to-back requests", 64'(b2b), 64'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule